// File: doc/BRIEF.md
# Accumulator processor with fetch, indirect and execute cycles

This block is a small accumulator machine. It fetches 16-bit instruction words from an external word-addressed memory and runs Load, Add and Store against a single accumulator. Every memory transfer goes through a memory address register and a memory buffer register.

Each instruction passes through up to three machine cycles. A fetch cycle always runs. An indirect cycle runs only when the instruction's indirect flag is set. An execute cycle runs only for memory-reference operations. Every machine cycle takes exactly four clock steps, t1 to t4.

The memory is synchronous. A read strobe in one cycle returns its data on the next cycle. A write takes effect at the clock edge that ends the cycle in which the write strobe is high. A halt opcode stops the machine and raises a status output. The program counter is visible as a second status output.

Top module: `acc_cpu`

## Requirements
- R1: Reset clears the accumulator, instruction register, address register and buffer register, and loads the program counter with START_PC (default 0x0300). While reset is held, `halted`, `mem_rd` and `mem_wr` are 0, and `mem_addr` and `mem_wdata` are 0.
- R2: Fetch behaves as follows:
  - t1 copies the PC into the address register.
  - t2 raises `mem_rd` with `mem_addr` equal to the PC.
  - t3 captures `mem_rdata` into the buffer register.
  - t4 moves the instruction into the instruction register and adds one to the PC.
  - The PC changes only by +1.
- R3: The instruction word is laid out as follows:
  - Bit 15 is the indirect flag.
  - Bits 14:12 hold the operation: 001 Load, 010 Store, 011 Add, 111 Halt.
  - Bits 11:0 hold the address field.
  - Any other operation value is a no-op. A no-op costs only its fetch cycle and makes no further memory access, whatever its indirect flag.
- R4: For a memory-reference operation with bit 15 clear, the effective address is the 12-bit field, zero-extended.
- R5: For a memory-reference operation with bit 15 set, an indirect cycle runs first:
  - It reads the word at the 12-bit field address.
  - That 16-bit word becomes the effective address, so it can reach any of the 64K words.
- R6: Load sets the accumulator to the word at the effective address. Add sets it to the accumulator plus that word, modulo 2^16.
- R7: Store writes the accumulator to the effective address, with exactly one write per Store. No other operation writes. Read and write strobes are never high together.
- R8: Each machine cycle is four clocks. An instruction therefore takes 4 clocks as a no-op or Halt. A direct memory-reference operation takes 8 clocks, and an indirect one takes 12.
- R9: After Halt is fetched, `halted` rises and stays high until reset. The PC stays frozen at the Halt address plus one, and no memory strobe is raised.
- R10: Read data is taken one cycle after the read strobe. Read strobes are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Memory address (address register) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (buffer register) |
| mem_rdata | input | 16 | Memory read data, valid the cycle after `mem_rd` |
| halted | output | 1 | High once a Halt has been fetched |
| pc | output | 16 | Program counter |

## Verification
The bench sweeps all eight combinations of indirect flags on Load, Add and Store. On top of that it varies:
- whether the first instruction is a no-op, which exposes an accumulator that was not cleared by reset;
- the no-op's flag bit, which exposes a spurious indirect cycle;
- the form of Halt;
- the operand data, including a carry out of bit 15.

Indirect pointers are placed above 4K. A design that truncates effective addresses to 12 bits then shows up as a wrong read or write address.

The full read address sequence and the clock count of each program are compared with values built from the instruction list. A miscounted step, an extra read or a missed indirect cycle therefore cannot go unnoticed.

After the halt, the bench keeps clocking the design. This catches a machine that keeps fetching or lets the PC drift.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW = 16,
  parameter int OPW = 4,
  parameter logic [DW-1:0] START_PC = 16'h0300
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted,
  output logic [DW-1:0] pc
);
  localparam int FW = DW - OPW;
  localparam logic [OPW-2:0] OP_LOAD  = (OPW-1)'(1);
  localparam logic [OPW-2:0] OP_STORE = (OPW-1)'(2);
  localparam logic [OPW-2:0] OP_ADD   = (OPW-1)'(3);
  localparam logic [OPW-2:0] OP_HALT  = '1;

  typedef enum logic [1:0] {PH_FETCH, PH_IND, PH_EXEC, PH_HALT} phase_t;

  phase_t         phase;
  logic [1:0]     step;
  logic [DW-1:0]  pc_q, ac, mar, mbr;
  logic [OPW-1:0] ir;

  wire            ir_ind  = ir[OPW-1];
  wire [OPW-2:0]  ir_op   = ir[OPW-2:0];
  wire            nxt_ind = mbr[DW-1];
  wire [OPW-2:0]  nxt_op  = mbr[DW-2:FW];
  wire            nxt_mem = (nxt_op == OP_LOAD) || (nxt_op == OP_STORE) || (nxt_op == OP_ADD);
  wire [DW-1:0]   field   = {{OPW{1'b0}}, mbr[FW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_FETCH;
      step  <= '0;
      pc_q  <= START_PC;
      ac    <= '0;
      ir    <= '0;
      mar   <= '0;
      mbr   <= '0;
    end else begin
      if (phase != PH_HALT) step <= step + 2'd1;
      case (phase)
        PH_FETCH: case (step)
          2'd0: mar <= pc_q;
          2'd2: mbr <= mem_rdata;
          2'd3: begin
            ir   <= mbr[DW-1:FW];
            pc_q <= pc_q + 1'b1;
            if (nxt_op == OP_HALT)  phase <= PH_HALT;
            else if (!nxt_mem)      phase <= PH_FETCH;
            else if (nxt_ind)       phase <= PH_IND;
            else                    phase <= PH_EXEC;
          end
          default: ;
        endcase
        PH_IND: case (step)
          2'd0: mar <= field;
          2'd2: mbr <= mem_rdata;
          2'd3: phase <= PH_EXEC;
          default: ;
        endcase
        PH_EXEC: case (step)
          2'd0: mar <= ir_ind ? mbr : field;
          2'd1: if (ir_op == OP_STORE) mbr <= ac;
          2'd2: if (ir_op != OP_STORE) mbr <= mem_rdata;
          2'd3: begin
            if (ir_op == OP_LOAD) ac <= mbr;
            if (ir_op == OP_ADD)  ac <= ac + mbr;
            phase <= PH_FETCH;
          end
          default: ;
        endcase
        default: ;
      endcase
    end
  end

  assign mem_rd    = (step == 2'd1) && ((phase == PH_FETCH) || (phase == PH_IND) ||
                     ((phase == PH_EXEC) && (ir_op != OP_STORE)));
  assign mem_wr    = (step == 2'd2) && (phase == PH_EXEC) && (ir_op == OP_STORE);
  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign halted    = (phase == PH_HALT);
  assign pc        = pc_q;
endmodule

module acc_cpu_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          halted,
  input logic [DW-1:0] pc,
  input logic [1:0]    step
);
  assert_no_dual_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_read_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> (pc == DW'($past(pc) + 1'b1)));
  assert_four_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> (halted || (step == 2'($past(step) + 2'd1))));
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));
  assert_halt_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc));
endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .halted(halted), .pc(pc), .step(step)
);

// File: tb/test_acc_cpu.sv
module test_acc_cpu;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata, pc;
  logic [15:0] mem_rdata = '0;
  logic mem_rd, mem_wr, halted;

  acc_cpu i_acc_cpu (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted), .pc(pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] mem [int];
  logic [15:0] rd_log [0:63];
  int rd_n = 0, wr_n = 0, cyc = 0;
  logic [15:0] waddr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_n <= 0; wr_n <= 0; cyc <= 0;
    end else begin
      if (mem_rd) begin
        mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0;
        if (rd_n < 64) rd_log[rd_n] <= mem_addr;
        rd_n <= rd_n + 1;
      end
      if (mem_wr) begin
        mem[int'(mem_addr)] = mem_wdata;
        wr_n <= wr_n + 1;
        waddr <= mem_addr;
      end
      if (!halted) cyc <= cyc + 1;
    end
  end

  int total = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rdm(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0;
  endfunction

  logic [15:0] exp_log [0:63];
  int exp_n;
  task automatic push(input logic [15:0] a);
    if (exp_n < 64) exp_log[exp_n] = a;
    exp_n++;
  endtask

  logic [31:0] lcg = 32'h1234_5678;
  function automatic logic [15:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[31:16];
  endfunction

  initial begin
    for (int k = 0; k < 32; k++) begin
      bit i0, i1, i2, nopv, wd;
      logic [11:0] fa, fb, fc;
      logic [15:0] ea, eb, ec, va, vb, expv, pc_h;
      int ecyc, rd_h;
      bit seq_ok;
      i0 = k[0]; i1 = k[1]; i2 = k[2]; nopv = k[3];
      mem.delete();
      va = rnd(); vb = rnd();
      if (k == 5) begin va = 16'hFFFF; vb = 16'h0001; end
      if (k == 6) begin va = 16'h8000; vb = 16'h8000; end
      ea = i0 ? (16'h8000 | 16'(k)) : (16'h0900 + 16'(k));
      eb = i1 ? (16'hC000 | 16'(k)) : (16'h0A00 + 16'(k));
      ec = i2 ? (16'hF000 | 16'(k)) : (16'h0B00 + 16'(k));
      fa = i0 ? (12'h500 + 12'(k)) : ea[11:0];
      fb = i1 ? (12'h600 + 12'(k)) : eb[11:0];
      fc = i2 ? (12'h700 + 12'(k)) : ec[11:0];
      if (i0) mem[int'({4'h0, fa})] = ea;
      if (i1) mem[int'({4'h0, fb})] = eb;
      if (i2) mem[int'({4'h0, fc})] = ec;
      mem[int'(ea)] = va;
      mem[int'(eb)] = vb;
      mem[int'(16'h0300)] = nopv ? {i0, 3'b000, fa} : {i0, 3'b001, fa};
      mem[int'(16'h0301)] = {i1, 3'b011, fb};
      mem[int'(16'h0302)] = {i2, 3'b010, fc};
      mem[int'(16'h0303)] = 16'h4123 | (k[4] ? 16'h8000 : 16'h0);
      mem[int'(16'h0304)] = k[4] ? 16'hF000 : 16'h7000;
      exp_n = 0;
      push(16'h0300);
      if (!nopv) begin if (i0) push({4'h0, fa}); push(ea); end
      push(16'h0301); if (i1) push({4'h0, fb}); push(eb);
      push(16'h0302); if (i2) push({4'h0, fc});
      push(16'h0303); push(16'h0304);
      ecyc = 20 + (nopv ? 0 : 4 + 4 * int'(i0)) + 4 + 4 * int'(i1) + 4 + 4 * int'(i2);
      expv = (nopv ? 16'h0 : va) + vb;

      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!halted && !mem_rd && !mem_wr, "R1 strobes/halt in reset", {halted, mem_rd, mem_wr}, 0);
      chk(pc == 16'h0300, "R1 reset pc", pc, 16'h0300);
      chk(mem_addr == 0 && mem_wdata == 0, "R1 reset mar/mbr", {mem_addr, mem_wdata}, 0);
      rst_n = 1'b1;
      wd = 1'b1;
      for (int t = 0; t < 400; t++) begin
        @(negedge clk);
        if (halted) begin wd = 1'b0; break; end
      end
      chk(!wd, "R9 watchdog halt reached", {31'd0, halted}, 1);
      if (wd) continue;
      chk(cyc == ecyc, "R8 cycle count", cyc, ecyc);
      chk(rdm(ec) == expv, "R6 result stored", rdm(ec), expv);
      chk(wr_n == 1, "R7 write count", wr_n, 1);
      chk(waddr == ec, "R7 R5 R4 store address", waddr, ec);
      chk(rdm(ea) == va && rdm(eb) == vb, "R7 operands untouched", {rdm(ea), rdm(eb)}, {va, vb});
      chk(rd_n == exp_n, "R3 R5 read count", rd_n, exp_n);
      seq_ok = (rd_n == exp_n);
      for (int j = 0; j < exp_n && j < 64; j++)
        if (rd_log[j] != exp_log[j]) seq_ok = 1'b0;
      chk(seq_ok, "R2 R4 R5 R10 read address sequence", rd_log[0], exp_log[0]);
      chk(pc == 16'h0305, "R9 pc after halt", pc, 16'h0305);
      pc_h = pc; rd_h = rd_n;
      repeat (6) @(negedge clk);
      chk(halted && pc == pc_h && rd_n == rd_h && wr_n == 1, "R9 halted quiet", {pc, 15'd0, halted}, {pc_h, 16'd1});
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL R9 global watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule